// File: doc/BRIEF.md
# Condition-field predicate mask builder

This block turns a vector instruction's condition-field predicate selectors into two per-element masks, one for the source and one for the destination. A request arrives over a valid/ready pair. It carries the vector length, a predicate mode code and one 3-bit selector for each of the two masks. In condition-field mode the block walks the elements from 0 upward. For each element it reads one 4-bit condition field through a one-hot read enable. It picks one bit of the returned field, optionally inverts it, and stores the result at that element's position in the mask. The source mask is built completely before the destination mask, because both use the same read port.

The state machine has six states. IDLE accepts a request and moves to SRC_REQ, or goes straight to DONE when no reads are needed. SRC_REQ drives the read enable and always moves to SRC_CAP. SRC_CAP captures the returned bit and moves back to SRC_REQ for the next element, or to DST_REQ after the last element. DST_REQ and DST_CAP repeat the same walk for the destination mask and lead to DONE. DONE holds the result valid until the consumer takes it, then returns to IDLE. The condition register file sits outside the block. Its read data is valid one clock after the read enable.

Top module: `cr_pred_mask`

## Requirements
- R1: insn_ready is high only in IDLE, and a request is taken on a clock edge where insn_valid and insn_ready are both high. mask_valid, src_mask, dst_mask and range_err stay constant while mask_valid is high and mask_ready is low. On the edge where mask_valid and mask_ready are both high the block returns to IDLE, so insn_ready is high in the next cycle.
- R2: For element i the read enable cr_ren is one-hot with its single set bit at position NUM_CR-1-(CR_BASE+i), so bit 7 names field 0. With the defaults (NUM_CR=8, CR_BASE=2), element 0 drives 8'b0010_0000.
- R3: Every element read takes one cycle with cr_ren active, followed by one capture cycle with cr_ren at zero. The data on cr_rdata during the capture cycle is the data used. Elements are read in increasing index order.
- R4: Selector bits [1:0] choose the bit cr_rdata[k] with k = sel[1:0], where 0 is less-than, 1 is greater-than, 2 is equal and 3 is summary-overflow.
- R5: The stored mask bit is the selected bit XOR selector bit [2], the invert flag.
- R6: In condition-field mode (mode_in = 2'b10) the block issues VL source reads, all before any of the VL destination reads, for 2*VL reads in total. The source reads use src_sel and the destination reads use dst_sel.
- R7: For any mode code other than 2'b10, both masks are all ones, no read is issued and mask_valid rises in the cycle after acceptance.
- R8: In condition-field mode every mask bit at position VL or above is zero.
- R9: With VL = 0 in condition-field mode, no read is issued, both masks are zero, range_err is low and mask_valid rises in the cycle after acceptance.
- R10: If CR_BASE+VL-1 > NUM_CR-1 in condition-field mode, range_err is high while mask_valid is high, no read is issued and both masks are zero. The next accepted request clears range_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Request present |
| insn_ready | output | 1 | Block can take a request (IDLE) |
| vl_in | input | VL_W | Vector length |
| mode_in | input | 2 | Predicate mode, 2'b10 selects condition fields |
| src_sel | input | 3 | Source selector: [2] invert, [1:0] bit index |
| dst_sel | input | 3 | Destination selector: [2] invert, [1:0] bit index |
| cr_ren | output | NUM_CR | One-hot condition field read enable |
| cr_rdata | input | 4 | Field data, valid one cycle after cr_ren |
| mask_valid | output | 1 | Masks are ready |
| mask_ready | input | 1 | Consumer takes the masks |
| src_mask | output | MASK_W | Source predicate mask |
| dst_mask | output | MASK_W | Destination predicate mask |
| range_err | output | 1 | Requested elements run past the last field |

## Verification
The register file model gives every field a different pattern, so a mask that was built from the wrong field or the wrong bit index comes out with a visibly different value. Selectors are applied with and without inversion across all four bit indices, and the two selectors of a request always differ, which exposes a source/destination swap. Every read enable is logged, and the log is compared against the expected order: the reversed one-hot position, increasing elements, and all source reads ahead of the destination reads. The other patterns cover the cases that must issue no reads: another mode code, zero length, and the largest valid length next to one element past it. Holding back mask_ready checks that the result stays stable and that no new request is taken in the meantime.

// File: rtl/cr_pred_pkg.sv
package cr_pred_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC_REQ,
        ST_SRC_CAP,
        ST_DST_REQ,
        ST_DST_CAP,
        ST_DONE
    } pm_state_e;

    localparam logic [1:0] MODE_CR = 2'b10;
endpackage

// File: rtl/cr_bit_pick.sv
module cr_bit_pick (
    input  logic [2:0] sel,
    input  logic [3:0] field,
    output logic       bit_out
);
    always_comb begin
        bit_out = field[sel[1:0]] ^ sel[2];
    end
endmodule

// File: rtl/cr_ren_gen.sv
module cr_ren_gen #(
    parameter int NUM_CR  = 8,
    parameter int CR_BASE = 2,
    parameter int IDX_W   = 3
) (
    input  logic             en,
    input  logic [IDX_W-1:0] elem,
    output logic [NUM_CR-1:0] ren
);
    for (genvar g = 0; g < NUM_CR; g++) begin : g_bit
        localparam int ELEM_FOR_BIT = NUM_CR - 1 - CR_BASE - g;
        if (ELEM_FOR_BIT >= 0) begin : g_live
            assign ren[g] = en && (elem == IDX_W'(ELEM_FOR_BIT));
        end else begin : g_dead
            assign ren[g] = 1'b0;
        end
    end
endmodule

// File: rtl/cr_pred_mask.sv
module cr_pred_mask
    import cr_pred_pkg::*;
#(
    parameter int MASK_W  = 64,
    parameter int VL_W    = 7,
    parameter int NUM_CR  = 8,
    parameter int CR_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    output logic              insn_ready,
    input  logic [VL_W-1:0]   vl_in,
    input  logic [1:0]        mode_in,
    input  logic [2:0]        src_sel,
    input  logic [2:0]        dst_sel,
    output logic [NUM_CR-1:0] cr_ren,
    input  logic [3:0]        cr_rdata,
    output logic              mask_valid,
    input  logic              mask_ready,
    output logic [MASK_W-1:0] src_mask,
    output logic [MASK_W-1:0] dst_mask,
    output logic              range_err
);
    localparam int IDX_W = (NUM_CR > 1) ? $clog2(NUM_CR) : 1;
    localparam logic [VL_W-1:0] VL_MAX = VL_W'(NUM_CR - CR_BASE);

    pm_state_e state, state_nx;

    logic [VL_W-1:0]  vl_q;
    logic [2:0]       ssel_q, dsel_q;
    logic [IDX_W-1:0] idx_q;
    logic             ren_en;
    logic             last_elem;
    logic [2:0]       cap_sel;
    logic             cap_bit;
    logic             accept;

    assign accept    = insn_valid && insn_ready;
    assign last_elem = (VL_W'(idx_q) == (vl_q - VL_W'(1)));
    assign cap_sel   = (state == ST_DST_CAP) ? dsel_q : ssel_q;

    cr_ren_gen #(.NUM_CR(NUM_CR), .CR_BASE(CR_BASE), .IDX_W(IDX_W)) u_ren (
        .en   (ren_en),
        .elem (idx_q),
        .ren  (cr_ren)
    );

    cr_bit_pick u_pick (
        .sel     (cap_sel),
        .field   (cr_rdata),
        .bit_out (cap_bit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx   = state;
        insn_ready = 1'b0;
        mask_valid = 1'b0;
        ren_en     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                insn_ready = 1'b1;
                if (insn_valid) begin
                    if (mode_in != MODE_CR || vl_in == '0 || vl_in > VL_MAX)
                        state_nx = ST_DONE;
                    else
                        state_nx = ST_SRC_REQ;
                end
            end
            ST_SRC_REQ: begin
                ren_en   = 1'b1;
                state_nx = ST_SRC_CAP;
            end
            ST_SRC_CAP: state_nx = last_elem ? ST_DST_REQ : ST_SRC_REQ;
            ST_DST_REQ: begin
                ren_en   = 1'b1;
                state_nx = ST_DST_CAP;
            end
            ST_DST_CAP: state_nx = last_elem ? ST_DONE : ST_DST_REQ;
            ST_DONE: begin
                mask_valid = 1'b1;
                if (mask_ready) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q      <= '0;
            ssel_q    <= '0;
            dsel_q    <= '0;
            idx_q     <= '0;
            src_mask  <= '0;
            dst_mask  <= '0;
            range_err <= 1'b0;
        end else if (accept) begin
            vl_q      <= vl_in;
            ssel_q    <= src_sel;
            dsel_q    <= dst_sel;
            idx_q     <= '0;
            range_err <= (mode_in == MODE_CR) && (vl_in > VL_MAX);
            if (mode_in != MODE_CR) begin
                src_mask <= '1;
                dst_mask <= '1;
            end else begin
                src_mask <= '0;
                dst_mask <= '0;
            end
        end else if (state == ST_SRC_CAP || state == ST_DST_CAP) begin
            if (state == ST_SRC_CAP) src_mask[idx_q] <= cap_bit;
            else                     dst_mask[idx_q] <= cap_bit;
            idx_q <= last_elem ? '0 : idx_q + IDX_W'(1);
        end
    end

    p_ren_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cr_ren));

    p_capture_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_ren != '0) |=> (cr_ren == '0));

    p_result_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && !mask_ready) |=>
            (mask_valid && $stable(src_mask) && $stable(dst_mask) && $stable(range_err)));

    p_no_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(insn_ready && mask_valid));

    p_no_read_on_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> (cr_ren == '0));
endmodule

// File: tb/tb_cr_pred_mask.sv
module tb_cr_pred_mask;
    localparam int MASK_W = 64;
    localparam int VL_W   = 7;
    localparam int NUM_CR = 8;
    localparam int BASE   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic insn_valid = 1'b0;
    logic insn_ready;
    logic [VL_W-1:0] vl_in = '0;
    logic [1:0] mode_in = '0;
    logic [2:0] src_sel = '0, dst_sel = '0;
    logic [NUM_CR-1:0] cr_ren;
    logic [3:0] cr_rdata = '0;
    logic mask_valid;
    logic mask_ready = 1'b1;
    logic [MASK_W-1:0] src_mask, dst_mask;
    logic range_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int nreads = 0;
    logic [NUM_CR-1:0] rlog [0:31];
    logic [3:0] crf [0:NUM_CR-1];

    always #4 clk = ~clk;

    cr_pred_mask #(.MASK_W(MASK_W), .VL_W(VL_W), .NUM_CR(NUM_CR), .CR_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
        .vl_in(vl_in), .mode_in(mode_in), .src_sel(src_sel), .dst_sel(dst_sel),
        .cr_ren(cr_ren), .cr_rdata(cr_rdata), .mask_valid(mask_valid),
        .mask_ready(mask_ready), .src_mask(src_mask), .dst_mask(dst_mask),
        .range_err(range_err)
    );

    // register file model and read log
    always @(posedge clk) begin
        if (cr_ren != '0) begin
            for (int p = 0; p < NUM_CR; p++)
                if (cr_ren[p]) cr_rdata <= crf[NUM_CR-1-p];
            if (nreads < 32) rlog[nreads] = cr_ren;
            nreads = nreads + 1;
        end
    end

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [MASK_W-1:0] act,
                         input logic [MASK_W-1:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [MASK_W-1:0] exp_mask(input int vl, input logic [2:0] sel);
        logic [MASK_W-1:0] m = '0;
        for (int i = 0; i < vl; i++) m[i] = crf[BASE+i][sel[1:0]] ^ sel[2];
        return m;
    endfunction

    // issue one request; returns with mask_valid high, sampled at a negedge
    task automatic start(input int vl, input logic [1:0] md,
                         input logic [2:0] ss, input logic [2:0] ds, output int lat);
        @(negedge clk);
        nreads = 0;
        vl_in = VL_W'(vl); mode_in = md; src_sel = ss; dst_sel = ds;
        insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
        lat = 1;
        while (!mask_valid && lat < 200) begin
            @(negedge clk);
            lat = lat + 1;
        end
    endtask

    task automatic finish_req();
        @(negedge clk);
        check("R1 ready after take", {63'd0, insn_ready}, 64'd1);
    endtask

    task automatic run_cr(input int vl, input logic [2:0] ss, input logic [2:0] ds, input string tag);
        int lat;
        start(vl, 2'b10, ss, ds, lat);
        check({tag, " valid"}, {63'd0, mask_valid}, 64'd1);
        check({tag, " src R4 R5 R8"}, src_mask, exp_mask(vl, ss));
        check({tag, " dst R4 R5 R8"}, dst_mask, exp_mask(vl, ds));
        check({tag, " R6 read count"}, 64'(nreads), 64'(2*vl));
        check({tag, " R3 latency"}, 64'(lat), 64'(4*vl + 1));
        for (int k = 0; k < 2*vl && k < 32; k++) begin
            int e = (k < vl) ? k : k - vl;
            check({tag, " R2 R3 R6 ren order"}, 64'(rlog[k]),
                  64'(8'(1) << (NUM_CR-1-(BASE+e))));
        end
        check({tag, " err"}, {63'd0, range_err}, 64'd0);
        finish_req();
    endtask

    task automatic t_reset();
        check("R1 reset ready", {63'd0, insn_ready}, 64'd1);
        check("R1 reset valid", {63'd0, mask_valid}, 64'd0);
        check("R2 reset ren", 64'(cr_ren), 64'd0);
        check("R10 reset err", {63'd0, range_err}, 64'd0);
    endtask

    task automatic t_other_mode(input logic [1:0] md);
        int lat;
        start(5, md, 3'b001, 3'b110, lat);
        check("R7 src ones", src_mask, '1);
        check("R7 dst ones", dst_mask, '1);
        check("R7 no reads", 64'(nreads), 64'd0);
        check("R7 latency", 64'(lat), 64'd1);
        finish_req();
    endtask

    task automatic t_zero_vl();
        int lat;
        start(0, 2'b10, 3'b000, 3'b101, lat);
        check("R9 src zero", src_mask, '0);
        check("R9 dst zero", dst_mask, '0);
        check("R9 no reads", 64'(nreads), 64'd0);
        check("R9 err low", {63'd0, range_err}, 64'd0);
        check("R9 latency", 64'(lat), 64'd1);
        finish_req();
    endtask

    task automatic t_overflow();
        int lat;
        start(NUM_CR - BASE + 1, 2'b10, 3'b000, 3'b111, lat);
        check("R10 err high", {63'd0, range_err}, 64'd1);
        check("R10 src zero", src_mask, '0);
        check("R10 dst zero", dst_mask, '0);
        check("R10 no reads", 64'(nreads), 64'd0);
        finish_req();
    endtask

    task automatic t_backpressure();
        int lat;
        logic [MASK_W-1:0] s0, d0;
        mask_ready = 1'b0;
        start(3, 2'b10, 3'b110, 3'b011, lat);
        s0 = src_mask; d0 = dst_mask;
        insn_valid = 1'b1;
        repeat (5) @(negedge clk);
        insn_valid = 1'b0;
        check("R1 held valid", {63'd0, mask_valid}, 64'd1);
        check("R1 held ready low", {63'd0, insn_ready}, 64'd0);
        check("R1 held src", src_mask, s0);
        check("R1 held dst", dst_mask, d0);
        check("R1 held src value", src_mask, exp_mask(3, 3'b110));
        mask_ready = 1'b1;
        finish_req();
        check("R1 no extra request taken", {63'd0, mask_valid}, 64'd0);
    endtask

    initial begin
        for (int f = 0; f < NUM_CR; f++) crf[f] = 4'(f * 5 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_other_mode(2'b00);
        t_other_mode(2'b01);
        run_cr(4, 3'b000, 3'b110, "cr vl4");
        run_cr(NUM_CR - BASE, 3'b101, 3'b011, "cr vlmax");
        run_cr(1, 3'b111, 3'b010, "cr vl1");
        t_zero_vl();
        t_overflow();
        run_cr(2, 3'b001, 3'b100, "R10 err cleared");
        t_backpressure();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule